// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Unit

This block holds the interrupt trigger logic for a row of general-purpose input pins. Each pin receives an already filtered (debounced) input level and its own configuration. A mode bit chooses level or edge sensing. A two-bit polarity field chooses high or rising, low or falling, or both edges. Further controls are an interrupt enable, an unmask bit and three wake enables, one for each of three sleep states. From these, every pin keeps an interrupt status bit and a wake status bit. Software clears each status bit with a one-cycle write-one strobe.

Each pin also drives a registered pending flag into a chip-level summary tree. The flag is high when the pin is unmasked and at least one of its two status bits is set. Enable and mask are separate controls. The enable decides whether the interrupt status can be set at all. The unmask bit only decides whether a status bit that is already set reaches the pending output. All inputs are synchronous to `clk`, and reset is synchronous and active high.

Top module: `gpio_irq_trigger`

## Requirements
- R1: While `rst` is high and on the first cycles after it, all interrupt status, wake status and pending bits are 0. A pin that is held high through reset does not count as a rising edge when reset is released.
- R2: With `lvl_mode`=0 and polarity code 2'b00, the interrupt status of a pin sets on the clock edge at which its level is 1 after being 0 on the previous clock. A falling transition does not set it, and other pins are not affected.
- R3: With `lvl_mode`=0 and polarity code 2'b01, the interrupt status sets on a 1-to-0 transition of the level and not on a 0-to-1 transition.
- R4: With `lvl_mode`=0 and polarity code 2'b10, the interrupt status sets on either transition.
- R5: With `lvl_mode`=1, polarity 2'b00 sets the status on every clock while the level is 1, and polarity 2'b01 sets it on every clock while the level is 0. A clear strobe issued while the level is still active leaves the status at 1, and an inactive level sets nothing.
- R6: Polarity code 2'b10 together with `lvl_mode`=1, and polarity code 2'b11 in either mode, never set the interrupt status or the wake status.
- R7: With `irq_en`=0 the interrupt status of that pin is never set. Wake detection for the pin is unaffected.
- R8: A detected event sets the wake status when at least one of the pin's three `wake_en` bits is 1, and does not set it when all three are 0.
- R9: A 1 on `clr_int` clears only the interrupt status, and a 1 on `clr_wake` clears only the wake status. Each takes effect at the next clock edge.
- R10: When a new event and the clear strobe for the same status bit fall in the same cycle, the status bit stays at 1.
- R11: The pending flag equals unmask AND (interrupt status OR wake status), registered. It follows the status bits one clock later and stays 0 while the pin is masked.
- R12: An edge-mode status bit stays set with no new event until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NPIN | Debounced input level per pin |
| lvl_mode | input | NPIN | 1 = level sensing, 0 = edge sensing |
| pol_sel | input | 2*NPIN | Polarity code per pin: 00 high/rising, 01 low/falling, 10 both edges, 11 reserved |
| irq_en | input | NPIN | Allows the interrupt status to set |
| irq_unmask | input | NPIN | Lets a set status reach the pending output |
| wake_en | input | 3*NPIN | Three sleep-state wake enables per pin |
| clr_int | input | NPIN | Write-one strobe clearing the interrupt status |
| clr_wake | input | NPIN | Write-one strobe clearing the wake status |
| int_sts | output | NPIN | Interrupt status per pin |
| wake_sts | output | NPIN | Wake status per pin |
| pending | output | NPIN | Registered pending flag to the summary tree |

## Verification
A fresh trigger event and the software clear of the same status bit can fall in the same clock. The bench provokes this in edge mode by raising the pin level in the same cycle as the `clr_int` strobe, and in level mode by pulsing the strobe while the active level is held. In both cases the status must read 1 after that edge. A strobe with no event present must read 0 one clock later, which shows that the clear path itself works.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;

  // Polarity codes; the decoder depends on these exact values.
  typedef enum logic [1:0] {
    POL_HIGH = 2'b00,  // active high / rising edge
    POL_LOW  = 2'b01,  // active low / falling edge
    POL_BOTH = 2'b10,  // both edges, edge mode only
    POL_RSVD = 2'b11   // reserved, never triggers
  } pol_e;

  localparam int WAKE_STATES = 3;
  localparam int POL_W       = 2;

endpackage

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_trig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic lvl_mode_i,
  input  pol_e pol_i,
  output logic event_o
);

  logic prev_q;
  logic rise, fall;

  // The previous-level register tracks the pin during reset too, so a pin
  // held high through reset does not look like an edge afterwards.
  always_ff @(posedge clk) begin
    prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    unique case (pol_i)
      POL_HIGH: event_o = lvl_mode_i ? level_i  : rise;
      POL_LOW:  event_o = lvl_mode_i ? ~level_i : fall;
      POL_BOTH: event_o = lvl_mode_i ? 1'b0     : (rise | fall);
      default:  event_o = 1'b0;
    endcase
  end

  // R6: an illegal combination never produces an event
  assert_no_event_illegal_R6: assert property (@(posedge clk) disable iff (rst)
    ((lvl_mode_i && pol_i == POL_BOTH) || pol_i == POL_RSVD) |-> !event_o);

  // R2: in rising-edge mode, a steady level produces no event
  assert_no_event_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode_i && pol_i == POL_HIGH && level_i == prev_q) |-> !event_o);

endmodule

// File: rtl/gpio_trig_status.sv
module gpio_trig_status
  import gpio_trig_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   event_i,
  input  logic                   irq_en_i,
  input  logic                   unmask_i,
  input  logic [WAKE_STATES-1:0] wake_en_i,
  input  logic                   clr_int_i,
  input  logic                   clr_wake_i,
  output logic                   int_sts_o,
  output logic                   wake_sts_o,
  output logic                   pending_o
);

  logic int_q, wake_q, pend_q;
  logic set_int, set_wake;

  assign set_int  = event_i & irq_en_i;
  assign set_wake = event_i & (|wake_en_i);

  // A new event outranks the clear strobe so that no trigger is lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= 1'b0;
      wake_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (set_int)        int_q <= 1'b1;
      else if (clr_int_i) int_q <= 1'b0;
      if (set_wake)        wake_q <= 1'b1;
      else if (clr_wake_i) wake_q <= 1'b0;
      pend_q <= unmask_i & (int_q | wake_q);
    end
  end

  assign int_sts_o  = int_q;
  assign wake_sts_o = wake_q;
  assign pending_o  = pend_q;

  // R9: a clear with no competing event empties the bit
  assert_clear_int_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_int_i && !event_i) |=> !int_q);
  assert_clear_wake_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_wake_i && !event_i) |=> !wake_q);

  // R7: a disabled pin keeps an empty interrupt status empty
  assert_disabled_stays_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!irq_en_i && !int_q) |=> !int_q);

  // R8: no wake enable keeps an empty wake status empty
  assert_no_wake_en_R8: assert property (@(posedge clk) disable iff (rst)
    (wake_en_i == '0 && !wake_q) |=> !wake_q);

  // R10: event together with clear leaves the bit set
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (event_i && irq_en_i && clr_int_i) |=> int_q);

  // R11: masked pins never raise pending; pending only follows a set status
  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !unmask_i |=> !pend_q);
  assert_pending_source_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(int_q | wake_q));

endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger
  import gpio_trig_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPIN-1:0]             pin_level,
  input  logic [NPIN-1:0]             lvl_mode,
  input  logic [POL_W*NPIN-1:0]       pol_sel,
  input  logic [NPIN-1:0]             irq_en,
  input  logic [NPIN-1:0]             irq_unmask,
  input  logic [WAKE_STATES*NPIN-1:0] wake_en,
  input  logic [NPIN-1:0]             clr_int,
  input  logic [NPIN-1:0]             clr_wake,
  output logic [NPIN-1:0]             int_sts,
  output logic [NPIN-1:0]             wake_sts,
  output logic [NPIN-1:0]             pending
);

  logic [NPIN-1:0] pin_event;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    gpio_trig_detect u_detect (
      .clk        (clk),
      .rst        (rst),
      .level_i    (pin_level[p]),
      .lvl_mode_i (lvl_mode[p]),
      .pol_i      (pol_e'(pol_sel[POL_W*p +: POL_W])),
      .event_o    (pin_event[p])
    );

    gpio_trig_status u_status (
      .clk        (clk),
      .rst        (rst),
      .event_i    (pin_event[p]),
      .irq_en_i   (irq_en[p]),
      .unmask_i   (irq_unmask[p]),
      .wake_en_i  (wake_en[WAKE_STATES*p +: WAKE_STATES]),
      .clr_int_i  (clr_int[p]),
      .clr_wake_i (clr_wake[p]),
      .int_sts_o  (int_sts[p]),
      .wake_sts_o (wake_sts[p]),
      .pending_o  (pending[p])
    );
  end

  // R1: reset leaves every output clear on the following cycle
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (int_sts == '0 && wake_sts == '0 && pending == '0));

endmodule

// File: tb/test_gpio_irq_trigger.sv
`timescale 1ns/1ps
module test_gpio_irq_trigger;

  localparam int NPIN = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NPIN-1:0]   pin_level = '0;
  logic [NPIN-1:0]   lvl_mode = '0;
  logic [2*NPIN-1:0] pol_sel = '0;
  logic [NPIN-1:0]   irq_en = '0;
  logic [NPIN-1:0]   irq_unmask = '0;
  logic [3*NPIN-1:0] wake_en = '0;
  logic [NPIN-1:0]   clr_int = '0;
  logic [NPIN-1:0]   clr_wake = '0;
  logic [NPIN-1:0]   int_sts, wake_sts, pending;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_trigger #(.NPIN(NPIN)) i_gpio_irq_trigger (
    .clk(clk), .rst(rst), .pin_level(pin_level), .lvl_mode(lvl_mode),
    .pol_sel(pol_sel), .irq_en(irq_en), .irq_unmask(irq_unmask),
    .wake_en(wake_en), .clr_int(clr_int), .clr_wake(clr_wake),
    .int_sts(int_sts), .wake_sts(wake_sts), .pending(pending)
  );

  // Fields: lvl, pol[1:0], en, wake[2:0], before, after, exp_int, exp_wake, req[3:0]
  localparam logic [14:0] VEC [16] = '{
    15'b0_00_1_000_0_1_1_0_0010,  // R2 rising sets
    15'b0_00_1_000_1_0_0_0_0010,  // R2 falling ignored
    15'b0_01_1_000_1_0_1_0_0011,  // R3 falling sets
    15'b0_01_1_000_0_1_0_0_0011,  // R3 rising ignored
    15'b0_10_1_000_0_1_1_0_0100,  // R4 rise
    15'b0_10_1_000_1_0_1_0_0100,  // R4 fall
    15'b1_00_1_000_0_1_1_0_0101,  // R5 level high
    15'b1_01_1_000_1_0_1_0_0101,  // R5 level low
    15'b1_10_1_111_0_1_0_0_0110,  // R6 both with level
    15'b1_10_1_111_1_0_0_0_0110,  // R6 both with level
    15'b0_11_1_111_0_1_0_0_0110,  // R6 reserved code
    15'b0_00_0_000_0_1_0_0_0111,  // R7 disabled
    15'b0_00_0_010_0_1_0_1_0111,  // R7 disabled, wake still sets
    15'b0_01_1_100_1_0_1_1_1000,  // R8 third wake enable
    15'b0_00_1_001_0_1_1_1_1000,  // R8 first wake enable
    15'b1_00_1_000_0_0_0_0_0101   // R5 inactive level
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_int = '1; clr_wake = '1;
    tick();
    clr_int = '0; clr_wake = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with pin 0 high and rising-edge mode enabled
    pin_level = 4'b0001; irq_en = 4'b1111;
    repeat (3) tick();
    check("R1 int during reset", int_sts, 0);
    rst = 1'b0;
    tick(); tick();
    check("R1 int after reset", int_sts, 0);
    check("R1 wake after reset", wake_sts, 0);
    check("R1 pending after reset", pending, 0);

    // vector table on pin 0
    for (int i = 0; i < 16; i++) begin
      logic [14:0] v;
      v = VEC[i];
      irq_unmask = '0;
      lvl_mode   = {3'b000, v[14]};
      pol_sel    = {6'b0, v[13:12]};
      irq_en     = {3'b000, v[11]};
      wake_en    = {9'b0, v[10:8]};
      pin_level  = {3'b000, v[7]};
      tick(); tick();
      clear_all();
      pin_level  = {3'b000, v[6]};
      tick();
      check($sformatf("R%0d int vec%0d", v[3:0], i), int_sts, {3'b000, v[5]});
      check($sformatf("R%0d wake vec%0d", v[3:0], i), wake_sts, {3'b000, v[4]});
    end

    // R12: edge status holds without new events
    lvl_mode = '0; pol_sel = '0; irq_en = 4'b0001; wake_en = '0; irq_unmask = '0;
    pin_level = '0;
    tick(); tick();
    clear_all();
    pin_level = 4'b0001;
    tick();
    check("R12 set", int_sts, 4'b0001);
    repeat (5) tick();
    check("R12 held", int_sts, 4'b0001);

    // R10: rising edge in the same cycle as the clear strobe
    pin_level = '0;
    tick(); tick();
    pin_level = 4'b0001; clr_int = 4'b0001;
    tick();
    clr_int = '0;
    check("R10 event beats clear", int_sts, 4'b0001);
    clr_int = 4'b0001;
    tick();
    clr_int = '0;
    check("R9 plain clear", int_sts, 0);

    // R9: clears are independent per status bit
    wake_en = 12'b001;
    pin_level = '0;
    tick(); tick();
    pin_level = 4'b0001;
    tick();
    check("R9 both set int", int_sts, 4'b0001);
    check("R9 both set wake", wake_sts, 4'b0001);
    clr_int = 4'b0001;
    tick();
    clr_int = '0;
    check("R9 int cleared", int_sts, 0);
    check("R9 wake kept", wake_sts, 4'b0001);
    clr_wake = 4'b0001;
    tick();
    clr_wake = '0;
    check("R9 wake cleared", wake_sts, 0);

    // R11: pending gating and one-cycle lag
    wake_en = '0;
    pin_level = '0;
    tick(); tick();
    pin_level = 4'b0001;
    tick();
    tick();
    check("R11 masked", pending, 0);
    irq_unmask = 4'b0001;
    tick();
    check("R11 unmasked", pending, 4'b0001);
    clr_int = 4'b0001;
    tick();
    clr_int = '0;
    check("R11 lag after clear", pending, 4'b0001);
    tick();
    check("R11 drops", pending, 0);
    irq_unmask = '0;

    // R5: clear while level still active
    lvl_mode = 4'b0001; pol_sel = '0;
    pin_level = 4'b0001;
    tick();
    check("R5 level set", int_sts, 4'b0001);
    clr_int = 4'b0001;
    tick();
    clr_int = '0;
    check("R5 re-set after clear", int_sts, 4'b0001);
    pin_level = '0;
    clr_int = 4'b0001;
    tick();
    clr_int = '0;
    check("R5 clear when inactive", int_sts, 0);
    tick();
    check("R5 stays clear", int_sts, 0);

    // R2: an edge on the last pin touches only that pin
    lvl_mode = '0; pol_sel = '0; irq_en = 4'b1000;
    pin_level = '0;
    tick(); tick();
    pin_level = 4'b1000;
    tick();
    check("R2 last pin only", int_sts, 4'b1000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule